// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks one core's load-exclusive / store-exclusive pairing. Each cycle the core may raise one or more notification strobes: ordinary load, exclusive load, ordinary store, exclusive store. Every strobe comes with a 32-bit address and a transfer-size code. An exclusive load arms the monitor. It stores the address with its low granule bits dropped, and it stores the size. A later exclusive store asks for permission. The block answers with a single combinational grant bit in the same cycle.

The grant is only the local half of the decision. The surrounding logic still has to ask the system-wide monitor, perform the write, and write back a status word. That status is 0 on success and 1 on failure. The block itself holds only three things: a one-bit state, a tagged address and a recorded size.

Top module: `excl_local_mon`

## Requirements
- R1: After reset the state is Open, the recorded size is None (code 0) and the tagged address is 0. An exclusive store issued right after reset is therefore refused.
- R2: Size codes are None=0, Byte=1, Halfword=2, Word=4. An exclusive load moves the monitor to Exclusive and records the tagged address and the size.
- R3: Address tagging ignores bits [10:0]. An exclusive store whose address differs from the armed address only in those bits is granted. A difference in any bit at or above bit 11 refuses it.
- R4: An exclusive store is granted only in Exclusive state when the size equals the recorded size. A different size refuses it.
- R5: Any exclusive store, granted or refused, returns the monitor to Open. A second exclusive store with the same arguments is then refused.
- R6: An ordinary store to any address while Exclusive returns the monitor to Open.
- R7: An ordinary load has no effect on the state. An exclusive store after it is still granted.
- R8: When several strobes arrive in one cycle, they are handled in this priority order: exclusive store, then ordinary store, then exclusive load, then ordinary load. Only the winner acts.
- R9: The grant output is combinational. It is valid in the cycle the exclusive-store strobe is high, and it is 0 whenever that strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Ordinary load strobe |
| ldx_i | input | 1 | Exclusive load strobe |
| st_i | input | 1 | Ordinary store strobe |
| stx_i | input | 1 | Exclusive store strobe |
| addr_i | input | 32 | Byte address of the access |
| size_i | input | 3 | Size code: 0 none, 1 byte, 2 halfword, 4 word |
| stx_ok_o | output | 1 | Exclusive store permitted by the local monitor |

## Verification
The state is visible only through the grant bit. A wrong state shows up at the next exclusive store, and that store also clears the state. So every scenario arms the monitor, applies one disturbing stimulus, and then probes with exactly one exclusive store. A state, address or size register that holds the wrong value shows up as a wrong grant within one cycle of that probe. The test then repeats the probe to confirm the monitor went back to Open.

// File: rtl/excl_local_mon.sv
module excl_local_mon #(
  parameter int AW = 32,
  parameter int GRAN_BITS = 11,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          ldx_i,
  input  logic          st_i,
  input  logic          stx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  output logic          stx_ok_o
);
  localparam int TW = AW - GRAN_BITS;

  logic          armed_q;
  logic [TW-1:0] tag_q;
  logic [SW-1:0] size_q;

  wire [TW-1:0] tag_in   = addr_i[AW-1:GRAN_BITS];
  wire          tag_hit  = (tag_in == tag_q);
  wire          size_hit = (size_i == size_q);

  assign stx_ok_o = stx_i && armed_q && tag_hit && size_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tag_q   <= '0;
      size_q  <= '0;
    end else if (stx_i || st_i) begin
      armed_q <= 1'b0;
    end else if (ldx_i) begin
      armed_q <= 1'b1;
      tag_q   <= tag_in;
      size_q  <= size_i;
    end
  end

  wire unused_ld = ld_i;
endmodule

module excl_local_mon_chk #(
  parameter int AW = 32,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_i,
  input logic          ldx_i,
  input logic          st_i,
  input logic          stx_i,
  input logic [AW-1:0] addr_i,
  input logic [SW-1:0] size_i,
  input logic          stx_ok_o
);
  p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stx_i |-> !stx_ok_o);

  p_stx_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stx_i |=> !(stx_i && stx_ok_o));

  p_st_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i && !stx_i) |=> !stx_ok_o);

  p_reset_open_r1: assert property (@(posedge clk)
    !rst_n |=> !stx_ok_o);

  p_ldx_then_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx_i && !st_i && !stx_i) |=> ((stx_i && !ldx_i && !st_i && $stable(addr_i) && $stable(size_i)) |-> stx_ok_o));

  wire unused_ld = ld_i;
endmodule

bind excl_local_mon excl_local_mon_chk #(.AW(AW), .SW(SW)) u_chk (.*);

// File: tb/test_excl_local_mon.sv
module test_excl_local_mon;
  logic clk = 0, rst_n = 0;
  logic ld_i = 0, ldx_i = 0, st_i = 0, stx_i = 0;
  logic [31:0] addr_i = 0;
  logic [2:0] size_i = 0;
  logic stx_ok_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  excl_local_mon i_excl_local_mon (.*);

  task automatic idle();
    ld_i = 0; ldx_i = 0; st_i = 0; stx_i = 0;
  endtask

  task automatic op(input bit l, lx, s, sx, input logic [31:0] a, input logic [2:0] z);
    @(negedge clk);
    ld_i = l; ldx_i = lx; st_i = s; stx_i = sx; addr_i = a; size_i = z;
  endtask

  task automatic check(input string req, input bit exp);
    #1;
    n_chk++;
    if (stx_ok_o !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%0b expected=%0b", req, stx_ok_o, exp);
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [2:0] z, input bit exp);
    op(0, 0, 0, 1, a, z); check(req, exp);
  endtask

  task automatic t_reset();
    probe("R1 after reset", 32'h0, 3'd0, 0);
    op(0, 0, 0, 0, 32'h0, 3'd0); check("R9 idle", 0);
  endtask

  task automatic t_basic();
    op(0, 1, 0, 0, 32'h1000_0800, 3'd4); check("R9 no stx", 0);
    probe("R2 match word", 32'h1000_0800, 3'd4, 1);
    probe("R5 second stx", 32'h1000_0800, 3'd4, 0);
    op(0, 1, 0, 0, 32'h0000_4000, 3'd1);
    probe("R2 match byte", 32'h0000_4000, 3'd1, 1);
  endtask

  task automatic t_granule();
    op(0, 1, 0, 0, 32'h2000_1800, 3'd2);
    probe("R3 low bits differ", 32'h2000_1FFE, 3'd2, 1);
    op(0, 1, 0, 0, 32'h2000_1800, 3'd2);
    probe("R3 bit11 differs", 32'h2000_1000, 3'd2, 0);
    op(0, 1, 0, 0, 32'h2000_1800, 3'd2);
    probe("R3 top bit differs", 32'hA000_1800, 3'd2, 0);
  endtask

  task automatic t_size();
    op(0, 1, 0, 0, 32'h3000_0000, 3'd4);
    probe("R4 size mismatch", 32'h3000_0000, 3'd2, 0);
    probe("R5 cleared after refusal", 32'h3000_0000, 3'd4, 0);
  endtask

  task automatic t_store_load();
    op(0, 1, 0, 0, 32'h4000_0000, 3'd4);
    op(0, 0, 1, 0, 32'h7777_0000, 3'd1);
    probe("R6 store clears", 32'h4000_0000, 3'd4, 0);
    op(0, 1, 0, 0, 32'h4000_0000, 3'd4);
    op(1, 0, 0, 0, 32'h5555_0000, 3'd1);
    probe("R7 load no effect", 32'h4000_0000, 3'd4, 1);
  endtask

  task automatic t_priority();
    op(0, 1, 1, 0, 32'h5000_0000, 3'd4);
    probe("R8 store beats ldx", 32'h5000_0000, 3'd4, 0);
    op(0, 1, 0, 0, 32'h6000_0000, 3'd4);
    op(0, 1, 0, 1, 32'h6000_0000, 3'd4); check("R8 stx wins grant", 1);
    probe("R8 ldx lost to stx", 32'h6000_0000, 3'd4, 0);
    op(1, 1, 0, 0, 32'h6100_0000, 3'd1);
    probe("R8 ldx beats ld", 32'h6100_0000, 3'd1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_basic(); t_granule(); t_size(); t_store_load(); t_priority();
    @(negedge clk); idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: done=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule